// File: doc/BRIEF.md
# Fuse PROM Program-and-Verify Sequencer

This block walks an external fuse programmer through the burn procedure of a small bipolar fuse PROM, one bit at a time. After a start pulse it scans every word in ascending address order and every bit from index 0 upward. For each bit whose target value is 1, it runs one burn cycle. The supply is raised to the programming level and the address is presented. Then chip enable 1 goes to its programming level and a single output gets a fusing pulse of fixed width. After the pulse the enable is released, and the bit is read back, first at the high verify supply and then at the low one. The cycle ends with a rest period with the supply off, which keeps the fusing duty cycle at or below one third. Bits whose target is 0 are skipped, because an unblown fuse already reads 0.

Every delay is a cycle count derived from the clock frequency parameter. The settle gap, the pulse width and the rest period are given in microseconds. The pulse width is checked at elaboration to lie within 1000 to 2000 µs, and the rest must be at least twice the pulse. A bit that fails either verify step gets further pulses, up to a parameter limit; each one is preceded by a rest. If the bit still fails, the block stops and reports the address and bit index. The target data arrive combinationally on `tgt_data` for the word currently shown on `prom_addr`. `sense` carries one comparator result per PROM output.

Top module: `fuse_burn_seq`

## Requirements
- R1: After reset the block is idle. `supply` is 0 (off), `ce1_prog`, `fuse_en`, `done`, `fail` and `busy` are all 0.
- R2: `ce2_level` stays 0 at all times, including during a session.
- R3: Burn pulses occur only for bits whose target is 1. They follow ascending address order and ascending bit index within a word. When a run completes, every blown bit equals the target data.
- R4: Before `ce1_prog` rises, `supply` is 3 (program) with a stable address for exactly SETTLE cycles. `ce1_prog` then leads `fuse_en` by exactly SETTLE cycles. The address does not change while `ce1_prog` is high.
- R5: `fuse_en` is at most one-hot, with bit i selecting output i. It is nonzero only while `supply` is 3 and `ce1_prog` is 1. Each pulse lasts exactly PULSE cycles.
- R6: After the pulse, `ce1_prog` stays high for SETTLE cycles and then falls. `supply` is then 1 (verify high) for SETTLE cycles, then 2 (verify low) for SETTLE cycles. The selected `sense` bit is sampled in the last cycle of each step.
- R7: After each burn cycle, `supply` is 0 for at least REST cycles before it returns to 3.
- R8: If either verify step reads 0, the same bit is pulsed again, with up to MAX_RETRY extra pulses.
- R9: If the last allowed pulse still fails verification, the block goes idle with `supply` 0 and `fuse_en` 0. It sets `fail` and holds `fail_addr` and `fail_bit` until the next start. No further bits are burnt.
- R10: After the last bit of the top address has been handled, `done` is 1 and `busy` is 0. A new start clears `done` and `fail` and begins a new scan from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a session when idle, done or failed |
| tgt_data | input | DATA_W | Target word for the address on `prom_addr` |
| sense | input | DATA_W | Verify comparator result per PROM output |
| prom_addr | output | ADDR_W | PROM address, also the target lookup index |
| supply | output | 2 | Supply level: 0 off, 1 verify high, 2 verify low, 3 program |
| ce1_prog | output | 1 | Drives chip enable 1 to its programming level |
| ce2_level | output | 1 | Chip enable 2 logic level, held 0 |
| fuse_en | output | DATA_W | One-hot fusing enable per output |
| busy | output | 1 | A session is in progress |
| done | output | 1 | Session finished with every bit verified |
| fail | output | 1 | Session stopped on a bit that would not verify |
| fail_addr | output | ADDR_W | Address of the failing bit |
| fail_bit | output | BIT_W | Index of the failing bit |

## Verification
Some rules are checked on every cycle by the assertions:
- `fuse_en` is one-hot.
- The pulse is gated by the program supply and chip enable 1.
- The address is stable while the enable is high.
- The pulse length is exact.
- `done` and `fail` never coincide, and a failed session stays quiet.

Other behaviour needs the bench and its fuse model:
- the ordering of pulses across addresses and bits;
- the spacing of the settle gaps and the rest period;
- extra pulses for marginal bits;
- the address and bit reported for a bit that never blows;
- the final array contents compared with the target.

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 4,
  parameter int CLK_KHZ   = 200000,
  parameter int SETTLE_US = 10,
  parameter int PULSE_US  = 1500,
  parameter int REST_US   = 4000,
  parameter int MAX_RETRY = 3,
  localparam int BIT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tgt_data,
  input  logic [DATA_W-1:0] sense,
  output logic [ADDR_W-1:0] prom_addr,
  output logic [1:0]        supply,
  output logic              ce1_prog,
  output logic              ce2_level,
  output logic [DATA_W-1:0] fuse_en,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [BIT_W-1:0]  fail_bit
);
  localparam int SETTLE_RAW = (CLK_KHZ * SETTLE_US) / 1000;
  localparam int PULSE_RAW  = (CLK_KHZ * PULSE_US) / 1000;
  localparam int REST_RAW   = (CLK_KHZ * REST_US) / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int PULSE_CYC  = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
  localparam int REST_CYC   = (REST_RAW < 1) ? 1 : REST_RAW;
  localparam int MAX_A      = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
  localparam int MAX_CYC    = (MAX_A > REST_CYC) ? MAX_A : REST_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int TRY_W      = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

  localparam logic [1:0] SUP_OFF = 2'd0, SUP_VHI = 2'd1, SUP_VLO = 2'd2, SUP_PRG = 2'd3;

  if (PULSE_US < 1000 || PULSE_US > 2000) begin : g_pulse_out_of_range
    $error("fuse_burn_seq: PULSE_US must lie within 1000..2000");
  end
  if (REST_US < 2 * PULSE_US) begin : g_rest_too_short
    $error("fuse_burn_seq: REST_US must be at least twice PULSE_US");
  end

  typedef enum logic [3:0] {
    ST_IDLE, ST_SCAN, ST_SETUP, ST_ARM, ST_FUSE, ST_HOLD,
    ST_VHI, ST_VLO, ST_REST, ST_DONE, ST_FAIL
  } state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt, dur;
  logic [ADDR_W-1:0]  addr;
  logic [BIT_W-1:0]   bit_idx;
  logic [TRY_W-1:0]   tries;
  logic               redo, adv;

  always_comb begin
    unique case (st)
      ST_SETUP, ST_ARM, ST_HOLD, ST_VHI, ST_VLO: dur = CNT_W'(SETTLE_CYC);
      ST_FUSE:                                  dur = CNT_W'(PULSE_CYC);
      ST_REST:                                  dur = CNT_W'(REST_CYC);
      default:                                  dur = CNT_W'(1);
    endcase
  end

  wire last      = (cnt == dur - 1'b1);
  wire last_bit  = (bit_idx == BIT_W'(DATA_W - 1));
  wire last_addr = (addr == {ADDR_W{1'b1}});
  wire seen      = sense[bit_idx];
  wire out_of_tries = (tries == TRY_W'(MAX_RETRY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      addr      <= '0;
      bit_idx   <= '0;
      tries     <= '0;
      redo      <= 1'b0;
      adv       <= 1'b0;
      fail_addr <= '0;
      fail_bit  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      unique case (st)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          cnt <= '0;
          if (start) begin
            st      <= ST_SCAN;
            addr    <= '0;
            bit_idx <= '0;
            adv     <= 1'b0;
          end
        end
        ST_SCAN: begin
          cnt <= '0;
          if (adv) begin
            adv <= 1'b0;
            if (last_bit) begin
              bit_idx <= '0;
              if (last_addr) st <= ST_DONE;
              else           addr <= addr + 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end else if (tgt_data[bit_idx]) begin
            st    <= ST_SETUP;
            tries <= '0;
          end else begin
            adv <= 1'b1;
          end
        end
        ST_SETUP: if (last) begin st <= ST_ARM;  cnt <= '0; end
        ST_ARM:   if (last) begin st <= ST_FUSE; cnt <= '0; end
        ST_FUSE:  if (last) begin st <= ST_HOLD; cnt <= '0; end
        ST_HOLD:  if (last) begin st <= ST_VHI;  cnt <= '0; end
        ST_VHI, ST_VLO: if (last) begin
          cnt <= '0;
          if (seen && st == ST_VHI) begin
            st <= ST_VLO;
          end else if (seen) begin
            st   <= ST_REST;
            redo <= 1'b0;
          end else if (out_of_tries) begin
            st        <= ST_FAIL;
            fail_addr <= addr;
            fail_bit  <= bit_idx;
          end else begin
            st    <= ST_REST;
            redo  <= 1'b1;
            tries <= tries + 1'b1;
          end
        end
        ST_REST: if (last) begin
          cnt <= '0;
          if (redo) st <= ST_SETUP;
          else begin
            st  <= ST_SCAN;
            adv <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign prom_addr = addr;
  assign ce2_level = 1'b0;
  assign ce1_prog  = (st == ST_ARM) || (st == ST_FUSE) || (st == ST_HOLD);
  assign fuse_en   = (st == ST_FUSE) ? ({{(DATA_W-1){1'b0}}, 1'b1} << bit_idx) : '0;
  assign supply    = (st == ST_SETUP || ce1_prog) ? SUP_PRG :
                     (st == ST_VHI) ? SUP_VHI :
                     (st == ST_VLO) ? SUP_VLO : SUP_OFF;
  assign busy      = !(st == ST_IDLE || st == ST_DONE || st == ST_FAIL);
  assign done      = (st == ST_DONE);
  assign fail      = (st == ST_FAIL);
endmodule

module fuse_burn_seq_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 4,
  parameter int PULSE_CYC = 300
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] prom_addr,
  input logic [1:0]        supply,
  input logic              ce1_prog,
  input logic [DATA_W-1:0] fuse_en,
  input logic              done,
  input logic              fail
);
  logic [31:0] pw;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pw <= '0;
    else if (|fuse_en) pw <= pw + 1;
    else               pw <= '0;
  end

  p_fuse_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fuse_en));
  p_fuse_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|fuse_en) |-> (supply == 2'd3 && ce1_prog));
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|fuse_en) && pw != 0) |-> (pw == PULSE_CYC));
  p_ce_on_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ce1_prog |-> (supply == 2'd3));
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ce1_prog |=> (!ce1_prog || $stable(prom_addr)));
  p_fuse_after_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|fuse_en) |-> $past(ce1_prog));
  p_fail_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (fuse_en == '0 && supply == 2'd0 && !ce1_prog));
  p_done_fail_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
endmodule

bind fuse_burn_seq fuse_burn_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .prom_addr(prom_addr), .supply(supply),
  .ce1_prog(ce1_prog), .fuse_en(fuse_en), .done(done), .fail(fail)
);

// File: tb/fuse_burn_seq_tb.sv
`timescale 1ns/1ps
module fuse_burn_seq_tb;
  localparam int AW = 4, DW = 4, BW = 2, DEPTH = 16;
  localparam int SET = 2, PUL = 200, RST = 800, MR = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DW-1:0] tgt_data, sense, fuse_en;
  logic [AW-1:0] prom_addr, fail_addr;
  logic [BW-1:0] fail_bit;
  logic [1:0] supply;
  logic ce1_prog, ce2_level, busy, done, fail;

  always #2.5 clk = ~clk;

  fuse_burn_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(200), .SETTLE_US(10),
                  .PULSE_US(1000), .REST_US(4000), .MAX_RETRY(MR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_data(tgt_data), .sense(sense),
    .prom_addr(prom_addr), .supply(supply), .ce1_prog(ce1_prog), .ce2_level(ce2_level),
    .fuse_en(fuse_en), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_bit(fail_bit));

  logic [DW-1:0] tgt [DEPTH];
  int need [DEPTH][DW];
  int hits [DEPTH][DW];
  int q[$];
  int checks = 0, failures = 0, cyc = 0;
  bit exp_fail;
  int exp_fa, exp_fb;

  assign tgt_data = tgt[prom_addr];

  always_comb begin
    for (int b = 0; b < DW; b++) begin
      int h, n;
      h = hits[prom_addr][b];
      n = need[prom_addr][b];
      if (supply == 2'd1)      sense[b] = (h >= 1) && (h >= n - 1);
      else if (supply == 2'd2) sense[b] = (h >= n);
      else                     sense[b] = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic load_expect();
    q.delete();
    exp_fail = 0;
    for (int a = 0; a < DEPTH; a++)
      for (int b = 0; b < DW; b++)
        if (tgt[a][b] && !exp_fail) begin
          int k;
          k = (need[a][b] > MR + 1) ? MR + 1 : need[a][b];
          for (int i = 0; i < k; i++) q.push_back(a * DW + b);
          if (need[a][b] > MR + 1) begin
            exp_fail = 1; exp_fa = a; exp_fb = b;
          end
        end
  endtask

  logic [1:0] p_sup;
  logic p_ce;
  logic [DW-1:0] p_fu;
  int t_sup, t_ce, t_fu, t_ff, t_hi, t_lo, t_off, cur_a, cur_b;
  bit have_rest;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (ce2_level !== 1'b0) chk(0, "R2 ce2_level", ce2_level, 0);
      if (supply == 2'd3 && p_sup != 2'd3) begin
        t_sup = cyc;
        if (have_rest) chk(cyc - t_off >= RST, "R7 rest length", cyc - t_off, RST);
      end
      if (ce1_prog && !p_ce) chk(cyc - t_sup == SET, "R4 supply to ce1", cyc - t_sup, SET);
      if (ce1_prog && !p_ce) t_ce = cyc;
      if (fuse_en != 0 && p_fu == 0) begin
        chk(cyc - t_ce == SET, "R4 ce1 to fuse", cyc - t_ce, SET);
        chk($countones(fuse_en) == 1, "R5 one-hot", fuse_en, 1);
        t_fu = cyc;
        cur_a = prom_addr;
        cur_b = 0;
        for (int b = 0; b < DW; b++) if (fuse_en[b]) cur_b = b;
        if (q.size() == 0) chk(0, "R3 unexpected pulse", cur_a * DW + cur_b, -1);
        else begin
          int e;
          e = q.pop_front();
          chk(e == cur_a * DW + cur_b, "R3/R8 pulse order", cur_a * DW + cur_b, e);
        end
      end
      if (fuse_en == 0 && p_fu != 0) begin
        chk(cyc - t_fu == PUL, "R5 pulse width", cyc - t_fu, PUL);
        hits[cur_a][cur_b]++;
        t_ff = cyc;
      end
      if (!ce1_prog && p_ce) chk(cyc - t_ff == SET, "R6 ce1 hold", cyc - t_ff, SET);
      if (supply == 2'd1 && p_sup != 2'd1) t_hi = cyc;
      if (supply == 2'd2 && p_sup == 2'd1) begin
        chk(cyc - t_hi == SET, "R6 verify high", cyc - t_hi, SET);
        t_lo = cyc;
      end
      if (supply == 2'd0 && p_sup == 2'd2)
        chk(cyc - t_lo == SET, "R6 verify low", cyc - t_lo, SET);
      if (supply == 2'd0 && p_sup != 2'd0) begin
        t_off = cyc;
        have_rest = 1;
      end
      p_sup = supply; p_ce = ce1_prog; p_fu = fuse_en;
      if (cyc > 190000) begin
        chk(0, "watchdog", cyc, 190000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end else begin
      p_sup = 0; p_ce = 0; p_fu = 0; have_rest = 0;
    end
  end

  task automatic run_session();
    load_expect();
    have_rest = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done && !fail, "R10 start clears status", {busy, done, fail}, 3'b100);
    while (!(done || fail)) @(negedge clk);
  endtask

  task automatic check_contents(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] w;
      for (int b = 0; b < DW; b++) w[b] = (hits[a][b] >= need[a][b]) && (hits[a][b] > 0);
      chk(w == tgt[a], tag, w, tgt[a]);
    end
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      tgt[a] = (a == 5) ? 4'h0 : (a == 15) ? 4'hF : 4'((a * 5 + 1) & 15);
      for (int b = 0; b < DW; b++) begin need[a][b] = 1; hits[a][b] = 0; end
    end
    need[2][0] = 2;
    need[6][3] = 3;
    repeat (4) @(negedge clk);
    chk(supply == 0 && !ce1_prog && fuse_en == 0, "R1 reset outputs", {supply, ce1_prog, fuse_en}, 0);
    chk(!done && !fail && !busy, "R1 reset status", {busy, done, fail}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && supply == 0, "R1 idle after reset", {busy, supply}, 0);

    run_session();
    chk(done && !fail && !busy, "R10 done", {busy, done, fail}, 3'b010);
    chk(supply == 0 && fuse_en == 0, "R10 quiet when done", {supply, fuse_en}, 0);
    chk(q.size() == 0, "R3/R8 all pulses seen", q.size(), 0);
    chk(!exp_fail, "R8 marginal bits recovered", exp_fail, 0);
    check_contents("R3 final contents");

    for (int a = 0; a < DEPTH; a++) begin
      tgt[a] = 4'h0;
      for (int b = 0; b < DW; b++) begin need[a][b] = 1; hits[a][b] = 0; end
    end
    tgt[0] = 4'h2; tgt[1] = 4'h8; tgt[3] = 4'h1;
    need[1][3] = 99;
    run_session();
    chk(fail && !done && !busy, "R9 fail flag", {busy, done, fail}, 3'b001);
    chk(fail_addr == AW'(exp_fa), "R9 fail_addr", fail_addr, exp_fa);
    chk(fail_bit == BW'(exp_fb), "R9 fail_bit", fail_bit, exp_fb);
    repeat (60) @(negedge clk);
    chk(fail && supply == 0 && fuse_en == 0, "R9 stays stopped", {fail, supply, fuse_en}, 1 << 6);
    chk(q.size() == 0, "R9 no pulse after failure", q.size(), 0);
    chk(hits[3][0] == 0, "R9 later address untouched", hits[3][0], 0);
    chk(fail_addr == AW'(1) && fail_bit == BW'(3), "R9 fault held", {fail_addr, fail_bit}, 7);

    need[1][3] = 1;
    run_session();
    chk(done && !fail, "R10 restart after fail", {done, fail}, 2'b10);
    chk(q.size() == 0, "R3 restart pulses", q.size(), 0);
    check_contents("R3 restart contents");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule